// File: doc/BRIEF.md
# Loop-back Built-In-Test Error Accumulator

This block watches a serial channel for silent corruption. For every word that the channel sends (or takes in on its main receive path), a second, redundant capture of that same word arrives through a loop-back path. The two words are presented together with a single valid strobe. The block compares them and keeps a leaky error score. A differing pair raises the score by two and a matching pair lowers it by one. The score saturates at both ends. A built-in-test error level is raised while the score is above a programmable limit and dropped while it is below that limit. When the score equals the limit, the level keeps its previous value.

Comparisons only count while the channel is active and its line clock is judged healthy. An edge watchdog counts system clock cycles since the last line-clock edge event. It flags a clock fault once a full timeout window passes with no edge. The fault is also set out of reset, until the first edge arrives. For every pair that is scored, a one-cycle mismatch flag is produced so that the stored word can be tagged with a test-error status bit. The host normally loads a limit of 4096 and sizes the timeout window to 320 µs of system clock.

Top module: `bit_loopback_monitor`

## Requirements
- R1: While reset is asserted and right after it, bit_error is 0, word_mismatch is 0, clk_fault is 1, and the internal score is 0.
- R2: A scored pair whose two words differ raises the score by 2.
- R3: A scored pair whose two words are equal lowers the score by 1.
- R4: A decrement from a score of 0 leaves the score at 0.
- R5: An increment never passes the maximum score 2^CNT_W-1. From that maximum or from one below it, the score becomes the maximum.
- R6: On the same edge that the score takes a new value, bit_error becomes 1 if the new score is greater than threshold and 0 if it is less. If the new score equals threshold, bit_error is unchanged. The rule is applied every cycle, so a change to threshold alone also acts on the next edge.
- R7: A pair presented while chan_active is 0 is not scored. The score is unchanged and word_mismatch stays 0.
- R8: A pair presented while clk_fault is 1 is not scored.
- R9: clk_fault goes to 0 on the edge after clk_edge is sampled high. It goes to 1 once WDOG_CYCLES consecutive edges have passed with clk_edge low.
- R10: word_mismatch is 1 for exactly the cycle after a scored pair whose words differ, and 0 otherwise.
- R11: bit_clear sampled high sets the score to 0 and bit_error to 0 on the next edge. It takes priority over a pair presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chan_active | input | 1 | Channel send or receive path enabled |
| clk_edge | input | 1 | One-cycle event: a line-clock edge was seen |
| bit_clear | input | 1 | Zero the score and drop bit_error |
| pair_valid | input | 1 | primary_word and loopback_word hold a pair to score |
| primary_word | input | WORD_W | Word from the main path |
| loopback_word | input | WORD_W | Same word from the redundant loop-back path |
| threshold | input | CNT_W | Error limit for the score |
| bit_error | output | 1 | Built-in-test error level |
| clk_fault | output | 1 | No line-clock edge within the timeout window |
| word_mismatch | output | 1 | Last scored pair differed |

## Verification
The bench builds the block with CNT_W of 6 and WDOG_CYCLES of 20. With these values, both saturation ends can be reached in a few dozen pairs and the timeout can be expired and restored many times in a short run. The score is not a port, so the bench finds it by moving threshold just below and just above the expected value and reading bit_error. A 32-bit word with one flipped bit at a random position drives the mismatch case.

// File: rtl/blt_pkg.sv
package blt_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2,
    CNT_ZERO = 2'd3
  } cnt_act_e;

  localparam int unsigned MISS_WEIGHT = 2;
  localparam int unsigned HIT_WEIGHT  = 1;
endpackage

// File: rtl/blt_edge_watchdog.sv
module blt_edge_watchdog #(
  parameter int unsigned LIMIT = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic fault
);
  localparam int unsigned WD_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [WD_W-1:0] LAST = WD_W'(LIMIT - 1);

  logic [WD_W-1:0] wd_q, wd_d;
  logic            fault_d;
  logic            wd_en;

  always_comb begin
    wd_d    = wd_q;
    fault_d = fault;
    if (edge_seen) begin
      wd_d    = '0;
      fault_d = 1'b0;
    end else if (wd_q == LAST) begin
      fault_d = 1'b1;
    end else begin
      wd_d = wd_q + 1'b1;
    end
  end

  assign wd_en = edge_seen | (wd_q != LAST) | ~fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q  <= '0;
      fault <= 1'b1;
    end else if (wd_en) begin
      wd_q  <= wd_d;
      fault <= fault_d;
    end
  end

  // R9: an edge event restores clock validity
  a_r9_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !fault);
  // R9: a full silent window raises the fault
  a_r9_silence_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && wd_q == LAST) |=> fault);
endmodule

// File: rtl/blt_leaky_counter.sv
module blt_leaky_counter
  import blt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_act_e         act,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] UP_W = CNT_W'(MISS_WEIGHT);
  localparam logic [CNT_W-1:0] DN_W = CNT_W'(HIT_WEIGHT);

  logic cnt_en;

  always_comb begin
    unique case (act)
      CNT_UP:   cnt_d = (cnt_q > CMAX - UP_W) ? CMAX : cnt_q + UP_W;
      CNT_DOWN: cnt_d = (cnt_q < DN_W) ? '0 : cnt_q - DN_W;
      CNT_ZERO: cnt_d = '0;
      default:  cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = (act != CNT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: a differing pair adds two below the ceiling
  a_r2_miss_adds_two: assert property (@(posedge clk) disable iff (!rst_n)
    (act == CNT_UP && cnt_q <= CMAX - UP_W) |=> cnt_q == $past(cnt_q) + UP_W);
  // R3: an equal pair takes one away above the floor
  a_r3_hit_subs_one: assert property (@(posedge clk) disable iff (!rst_n)
    (act == CNT_DOWN && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DN_W);
  // R4: the floor holds
  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (act == CNT_DOWN && cnt_q == '0) |=> cnt_q == '0);
  // R5: the ceiling holds
  a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (act == CNT_UP && cnt_q > CMAX - UP_W) |=> cnt_q == CMAX);
endmodule

// File: rtl/blt_threshold_latch.sv
module blt_threshold_latch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] limit,
  output logic             err
);
  logic err_d;

  always_comb begin
    err_d = err;
    if (clear) begin
      err_d = 1'b0;
    end else if (level > limit) begin
      err_d = 1'b1;
    end else if (level < limit) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else begin
      err <= err_d;
    end
  end

  // R6: equality leaves the level alone
  a_r6_equal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && level == limit) |=> err == $past(err));
  // R11: clear drops the level
  a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !err);
endmodule

// File: rtl/bit_loopback_monitor.sv
module bit_loopback_monitor
  import blt_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned WDOG_CYCLES = 32000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_active,
  input  logic              clk_edge,
  input  logic              bit_clear,
  input  logic              pair_valid,
  input  logic [WORD_W-1:0] primary_word,
  input  logic [WORD_W-1:0] loopback_word,
  input  logic [CNT_W-1:0]  threshold,
  output logic              bit_error,
  output logic              clk_fault,
  output logic              word_mismatch
);
  logic             differ;
  logic             score_en;
  cnt_act_e         act;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             mm_d;

  assign differ   = (primary_word != loopback_word);
  assign score_en = pair_valid & chan_active & ~clk_fault;

  always_comb begin
    if (bit_clear)     act = CNT_ZERO;
    else if (score_en) act = differ ? CNT_UP : CNT_DOWN;
    else               act = CNT_HOLD;
  end

  assign mm_d = score_en & ~bit_clear & differ;

  blt_edge_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_seen (clk_edge),
    .fault     (clk_fault)
  );

  blt_leaky_counter #(.CNT_W(CNT_W)) u_score (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .cnt_d (cnt_d),
    .cnt_q (cnt_q)
  );

  blt_threshold_latch #(.CNT_W(CNT_W)) u_decide (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (bit_clear),
    .level (cnt_d),
    .limit (threshold),
    .err   (bit_error)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_mismatch <= 1'b0;
    end else begin
      word_mismatch <= mm_d;
    end
  end

  // R6: a new score above the limit raises the error on that edge
  a_r6_above_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_clear && cnt_d > threshold) |=> bit_error);
  // R6: a new score below the limit drops the error on that edge
  a_r6_below_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_clear && cnt_d < threshold) |=> !bit_error);
  // R7: an inactive channel leaves the score alone
  a_r7_inactive_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_active && !bit_clear) |=> $stable(cnt_q));
  // R8: a clock fault freezes scoring
  a_r8_fault_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fault && !bit_clear) |=> $stable(cnt_q));
  // R10: the tag only follows a differing pair
  a_r10_tag_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_valid || !differ) |=> !word_mismatch);
  // R11: clear zeroes the score even against a pair
  a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clear |=> (cnt_q == '0 && !word_mismatch));
endmodule

// File: tb/bit_loopback_monitor_bench.sv
module bit_loopback_monitor_bench;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned WDOG   = 20;
  localparam int          MAXC   = (1 << CNT_W) - 1;
  localparam time         CLK_PERIOD = 10ns;

  logic              clk;
  logic              rst_n;
  logic              act, ev, clr, pv;
  logic [WORD_W-1:0] pa, pb;
  logic [CNT_W-1:0]  thr;
  logic              bit_error, clk_fault, word_mismatch;

  int checks   = 0;
  int failures = 0;

  int m_cnt, m_wd;
  bit m_err, m_fault, m_mm;

  bit_loopback_monitor #(.WORD_W(WORD_W), .CNT_W(CNT_W), .WDOG_CYCLES(WDOG)) u_bit_loopback_monitor (
    .clk (clk), .rst_n (rst_n), .chan_active (act), .clk_edge (ev),
    .bit_clear (clr), .pair_valid (pv), .primary_word (pa),
    .loopback_word (pb), .threshold (thr), .bit_error (bit_error),
    .clk_fault (clk_fault), .word_mismatch (word_mismatch)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int score_next(int c, bit differ);
    if (differ) return (c + 2 > MAXC) ? MAXC : c + 2;
    return (c == 0) ? 0 : c - 1;
  endfunction

  // one clock: model update from the requirements, then compare away from the edge
  task automatic cyc();
    int  n;
    bit  scored;
    @(posedge clk);
    scored = pv && act && !m_fault && !clr;
    n = m_cnt;
    if (clr) n = 0;
    else if (scored) n = score_next(m_cnt, pa != pb);
    m_mm = scored && (pa != pb);
    if (clr) m_err = 0;
    else if (n > int'(thr)) m_err = 1;
    else if (n < int'(thr)) m_err = 0;
    m_cnt = n;
    if (ev) begin m_wd = 0; m_fault = 0; end
    else if (m_wd == WDOG - 1) m_fault = 1;
    else m_wd++;
    @(negedge clk);
    chk(bit_error == m_err, "R6 bit_error", int'(bit_error), int'(m_err));
    chk(clk_fault == m_fault, "R9 clk_fault", int'(clk_fault), int'(m_fault));
    chk(word_mismatch == m_mm, "R10 word_mismatch", int'(word_mismatch), int'(m_mm));
  endtask

  task automatic pairs(bit differ, int n);
    for (int i = 0; i < n; i++) begin
      pv = 1'b1;
      pa = $urandom;
      pb = differ ? (pa ^ (32'd1 << ($urandom % WORD_W))) : pa;
      cyc();
    end
    pv = 1'b0;
  endtask

  // find the score through the ports by moving the limit around it
  task automatic probe(int expected, string tag);
    if (expected > 0) begin
      thr = CNT_W'(expected - 1);
      cyc();
      chk(bit_error == 1'b1, tag, int'(bit_error), 1);
    end
    if (expected < MAXC) begin
      thr = CNT_W'(expected + 1);
      cyc();
      chk(bit_error == 1'b0, tag, int'(bit_error), 0);
    end
  endtask

  task automatic run_all();
    int gap;
    void'($urandom(32'h5EED_0BC7));
    rst_n = 1'b0; act = 0; ev = 0; clr = 0; pv = 0; pa = '0; pb = '0; thr = '0;
    m_cnt = 0; m_wd = 0; m_err = 0; m_fault = 1; m_mm = 0;
    repeat (3) @(negedge clk);
    chk(bit_error == 1'b0, "R1 bit_error in reset", int'(bit_error), 0);
    chk(clk_fault == 1'b1, "R1 clk_fault in reset", int'(clk_fault), 1);
    chk(word_mismatch == 1'b0, "R1 word_mismatch in reset", int'(word_mismatch), 0);
    rst_n = 1'b1;
    thr = CNT_W'(MAXC);
    act = 1'b1;
    cyc();
    chk(clk_fault == 1'b1, "R1 clk_fault before first edge", int'(clk_fault), 1);
    probe(0, "R1 score zero after reset");
    thr = CNT_W'(MAXC);
    ev = 1'b1;
    cyc();
    chk(clk_fault == 1'b0, "R9 edge restores clock", int'(clk_fault), 0);

    pairs(1, 5);  probe(10, "R2 five misses give 10");
    pairs(0, 3);  probe(7, "R3 three hits give 7");
    thr = 7; cyc();
    chk(bit_error == 1'b0, "R6 equal limit holds 0", int'(bit_error), 0);
    thr = 6; cyc(); thr = 7; cyc();
    chk(bit_error == 1'b1, "R6 equal limit holds 1", int'(bit_error), 1);
    pairs(0, 12); pairs(1, 1);
    probe(2, "R4 floor then one miss gives 2");

    thr = CNT_W'(MAXC);
    pairs(1, 40);
    probe(MAXC, "R5 ceiling reached");
    thr = CNT_W'(MAXC); pairs(1, 2);
    thr = CNT_W'(MAXC - 1); cyc();
    chk(bit_error == 1'b1, "R5 no wrap past ceiling", int'(bit_error), 1);
    pairs(0, 1);
    probe(MAXC - 1, "R5 one hit from ceiling");

    clr = 1'b1; pv = 1'b1; pa = 32'hA5A5_0001; pb = 32'h0; cyc();
    clr = 1'b0; pv = 1'b0;
    chk(bit_error == 1'b0, "R11 clear drops error", int'(bit_error), 0);
    chk(word_mismatch == 1'b0, "R11 clear beats pair", int'(word_mismatch), 0);
    thr = CNT_W'(MAXC); pairs(1, 1);
    probe(2, "R11 score restarted from 0");

    act = 1'b0; pairs(1, 10);
    chk(word_mismatch == 1'b0, "R7 inactive no tag", int'(word_mismatch), 0);
    act = 1'b1;
    probe(2, "R7 inactive pairs ignored");

    ev = 1'b0;
    repeat (WDOG - 1) cyc();
    chk(clk_fault == 1'b0, "R9 fault not before window", int'(clk_fault), 0);
    cyc();
    chk(clk_fault == 1'b1, "R9 fault at window end", int'(clk_fault), 1);
    pairs(1, 6);
    ev = 1'b1; cyc();
    probe(2, "R8 pairs ignored under clock fault");

    pairs(1, 1);
    chk(word_mismatch == 1'b1, "R10 tag after miss", int'(word_mismatch), 1);
    cyc();
    chk(word_mismatch == 1'b0, "R10 tag one cycle only", int'(word_mismatch), 0);
    pairs(0, 1);
    chk(word_mismatch == 1'b0, "R10 no tag after hit", int'(word_mismatch), 0);

    gap = 0;
    for (int i = 0; i < 6000; i++) begin
      act = ($urandom % 10) != 0;
      if (gap > 0) begin ev = 1'b0; gap--; end
      else ev = ($urandom % 3) != 0;
      if ($urandom % 250 == 0) gap = 15 + ($urandom % 15);
      clr = ($urandom % 300) == 0;
      if ($urandom % 40 == 0) thr = CNT_W'($urandom);
      pv = $urandom % 2;
      pa = $urandom;
      pb = (($urandom % 3) == 0) ? (pa ^ (32'd1 << ($urandom % WORD_W))) : pa;
      cyc();
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule